// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block holds a 64-bit accumulator, kept as a high word and a low word, and updates it with one of two arithmetic operations. The first is a full-width multiply of two 32-bit operands, either unsigned or two's complement. Its 64-bit product replaces the whole accumulator. The second is a signed 16x16 multiply whose 32-bit product is added into the accumulator.

The accumulate has two modes, chosen by a per-operation flag. In saturating mode the low word clamps at the 32-bit signed limits, and bit 0 of the high word records overflow as a sticky flag. In wrapping mode the high word acts as a 10-bit sign-extended guard field above the low word.

Each operation is presented with a valid strobe and takes effect at the next clock edge. A clear input zeroes the accumulator. The operands are expected to be already fetched; nothing here touches memory.

Top module: `mac_unit`

## Requirements
- R1: After reset, mach_o and macl_o are both zero.
- R2: With clr_i high at a clock edge, both accumulator words become zero at that edge, whatever vld_i and op_i carry.
- R3: With vld_i high and op_i = 2'b00, the unsigned 64-bit product opa_i*opb_i is loaded. The upper 32 bits go to mach_o and the lower 32 bits to macl_o.
- R4: With vld_i high and op_i = 2'b01, the two's complement 64-bit product of opa_i and opb_i is loaded, split the same way as in R3.
- R5: With vld_i high and op_i = 2'b10, the 32-bit product of the sign-extended operands opa_i[15:0] and opb_i[15:0] is added to macl_o, modulo 2^32, whenever no clamp occurs. Bits 31:16 of both operands have no effect.
- R6: In the accumulate with sat_i low, the new mach_o is computed as follows. Take the old mach_o, add the product's sign extension (all ones if the product is negative) and the carry out of the low 32-bit sum. Then sign-extend the result from bit 9.
- R7: In the accumulate with sat_i high, when the signed low-word sum does not overflow, mach_o is unchanged.
- R8: In the accumulate with sat_i high, a signed overflow with a non-negative product sets macl_o to 32'h7FFFFFFF. An overflow is a product and old macl_o of the same sign whose sum has the other sign. The overflow also ORs 1 into mach_o bit 0, which then stays set through later non-overflowing saturating accumulates.
- R9: In the accumulate with sat_i high, a signed overflow with a negative product sets macl_o to 32'h80000000 and ORs 1 into mach_o bit 0.
- R10: With vld_i low, or with op_i = 2'b11, and clr_i low, the accumulator holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous accumulator clear, highest priority |
| vld_i | input | 1 | Operation strobe |
| op_i | input | 2 | 00 unsigned multiply, 01 signed multiply, 10 word accumulate, 11 no operation |
| sat_i | input | 1 | Saturating mode for the word accumulate |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| mach_o | output | 32 | Accumulator high word |
| macl_o | output | 32 | Accumulator low word |

## Verification
The bench drives the guard field across its boundary. It loads a high word of 0x1FF and then forces a carry from the low word; a design that fails to sign-extend from bit 9 would show 0x200 instead of 0xFFFFFE00.

Saturation is driven in both directions, starting from low words placed near each limit by a multiply. A wrong clamp constant or a wrong overflow test leaves a wrapped low word. A non-sticky overflow bit is exposed by a later accumulate that does not overflow.

Signed multiplies with the most negative operand and mixed signs catch a missing or swapped high-word correction. Accumulates with garbage in the operands' upper halves catch any leakage of those bits, and a long random sequence mixing every operation, clear and idle cycles is compared against a behavioural model.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    OP_MULU = 2'b00,
    OP_MULS = 2'b01,
    OP_MACW = 2'b10,
    OP_NOP  = 2'b11
  } mac_op_e;
endpackage

// File: rtl/mac_wide_mul.sv
module mac_wide_mul #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          sgn_i,
  output logic [DW-1:0] hi_o,
  output logic [DW-1:0] lo_o
);
  localparam int HW = DW / 2;

  logic [DW-1:0] pp [2][2];

  for (genvar i = 0; i < 2; i++) begin : g_pa
    for (genvar j = 0; j < 2; j++) begin : g_pb
      assign pp[i][j] = {{HW{1'b0}}, a_i[i*HW +: HW]} * {{HW{1'b0}}, b_i[j*HW +: HW]};
    end
  end

  logic [DW:0]   mid;
  logic [DW:0]   lo_sum;
  logic [DW-1:0] hi_raw;
  logic [DW-1:0] fix_a;
  logic [DW-1:0] fix_b;

  assign mid    = {1'b0, pp[1][0]} + {1'b0, pp[0][1]};
  assign lo_sum = {1'b0, pp[0][0]} + {1'b0, mid[HW-1:0], {HW{1'b0}}};
  assign hi_raw = pp[1][1] + DW'(mid[DW:HW]) + DW'(lo_sum[DW]);

  // two's complement correction of the unsigned upper word
  assign fix_a = (sgn_i && a_i[DW-1]) ? b_i : '0;
  assign fix_b = (sgn_i && b_i[DW-1]) ? a_i : '0;

  assign hi_o = hi_raw - fix_a - fix_b;
  assign lo_o = lo_sum[DW-1:0];
endmodule

// File: rtl/mac_word_acc.sv
module mac_word_acc #(
  parameter int DW = 32,
  parameter int GW = 10
) (
  input  logic [DW/2-1:0] a_i,
  input  logic [DW/2-1:0] b_i,
  input  logic [DW-1:0]   mach_i,
  input  logic [DW-1:0]   macl_i,
  input  logic            sat_i,
  output logic [DW-1:0]   mach_o,
  output logic [DW-1:0]   macl_o
);
  localparam int HW = DW / 2;

  logic [DW-1:0] ext_a;
  logic [DW-1:0] ext_b;
  logic [DW-1:0] prod;
  logic [DW:0]   sum;
  logic          ovf;
  logic [DW-1:0] guard_sum;

  assign ext_a = {{HW{a_i[HW-1]}}, a_i};
  assign ext_b = {{HW{b_i[HW-1]}}, b_i};
  assign prod  = ext_a * ext_b;
  assign sum   = {1'b0, macl_i} + {1'b0, prod};
  assign ovf   = (prod[DW-1] == macl_i[DW-1]) && (sum[DW-1] != prod[DW-1]);

  assign guard_sum = mach_i + {DW{prod[DW-1]}} + DW'(sum[DW]);

  always_comb begin
    mach_o = mach_i;
    macl_o = sum[DW-1:0];
    if (sat_i) begin
      if (ovf) begin
        mach_o = mach_i | DW'(1);
        macl_o = prod[DW-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
      end
    end else begin
      mach_o = {{(DW-GW){guard_sum[GW-1]}}, guard_sum[GW-1:0]};
    end
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int DW = 32,
  parameter int GW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          vld_i,
  input  logic [1:0]    op_i,
  input  logic          sat_i,
  input  logic [DW-1:0] opa_i,
  input  logic [DW-1:0] opb_i,
  output logic [DW-1:0] mach_o,
  output logic [DW-1:0] macl_o
);
  localparam int HW = DW / 2;

  mac_op_e       op;
  logic [DW-1:0] mul_hi, mul_lo;
  logic [DW-1:0] acc_hi, acc_lo;
  logic [DW-1:0] mach_q, macl_q;
  logic [DW-1:0] mach_d, macl_d;

  assign op = mac_op_e'(op_i);

  mac_wide_mul #(.DW(DW)) i_wide_mul (
    .a_i   (opa_i),
    .b_i   (opb_i),
    .sgn_i (op == OP_MULS),
    .hi_o  (mul_hi),
    .lo_o  (mul_lo)
  );

  mac_word_acc #(.DW(DW), .GW(GW)) i_word_acc (
    .a_i    (opa_i[HW-1:0]),
    .b_i    (opb_i[HW-1:0]),
    .mach_i (mach_q),
    .macl_i (macl_q),
    .sat_i  (sat_i),
    .mach_o (acc_hi),
    .macl_o (acc_lo)
  );

  always_comb begin
    mach_d = mach_q;
    macl_d = macl_q;
    if (clr_i) begin
      mach_d = '0;
      macl_d = '0;
    end else if (vld_i) begin
      unique case (op)
        OP_MULU, OP_MULS: begin
          mach_d = mul_hi;
          macl_d = mul_lo;
        end
        OP_MACW: begin
          mach_d = acc_hi;
          macl_d = acc_lo;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mach_q <= '0;
      macl_q <= '0;
    end else begin
      mach_q <= mach_d;
      macl_q <= macl_d;
    end
  end

  assign mach_o = mach_q;
  assign macl_o = macl_q;
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int DW = 32,
  parameter int GW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          clr_i,
  input logic          vld_i,
  input logic [1:0]    op_i,
  input logic          sat_i,
  input logic [DW-1:0] mach_o,
  input logic [DW-1:0] macl_o
);
  logic sat_acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sat_acc_q <= 1'b0;
    else         sat_acc_q <= !clr_i && vld_i && op_i == 2'b10 && sat_i;
  end

  a_r2_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (mach_o == '0 && macl_o == '0));

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && (!vld_i || op_i == 2'b11)) |=> ($stable(mach_o) && $stable(macl_o)));

  a_r7_sat_high_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && vld_i && op_i == 2'b10 && sat_i) |=>
      (mach_o[DW-1:1] == $past(mach_o[DW-1:1]) && (mach_o[0] || !$past(mach_o[0]))));

  a_r6_guard_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && vld_i && op_i == 2'b10 && !sat_i) |=>
      ((&mach_o[DW-1:GW-1]) || !(|mach_o[DW-1:GW-1])));

  a_r8_clamp_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_acc_q && $rose(mach_o[0])) |->
      (macl_o == {1'b0, {(DW-1){1'b1}}} || macl_o == {1'b1, {(DW-1){1'b0}}}));
endmodule

bind mac_unit mac_unit_chk #(.DW(DW), .GW(GW)) i_mac_unit_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .clr_i  (clr_i),
  .vld_i  (vld_i),
  .op_i   (op_i),
  .sat_i  (sat_i),
  .mach_o (mach_o),
  .macl_o (macl_o)
);

// File: tb/test_mac_unit.sv
`timescale 1ns/1ps
module test_mac_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clr_i = 1'b0;
  logic        vld_i = 1'b0;
  logic [1:0]  op_i = 2'b11;
  logic        sat_i = 1'b0;
  logic [31:0] opa_i = '0;
  logic [31:0] opb_i = '0;
  logic [31:0] mach_o, macl_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit [31:0] m_hi = '0;
  bit [31:0] m_lo = '0;

  always #2.5 clk_i = ~clk_i;

  mac_unit i_mac_unit (.*);

  task automatic model_step(bit clr, bit vld, bit [1:0] op, bit sat, bit [31:0] a, bit [31:0] b);
    longint unsigned pu;
    longint          ps;
    int              p, t;
    bit [31:0]       s;
    longint unsigned tot;
    bit              cy, ovf;
    if (clr) begin
      m_hi = '0; m_lo = '0;
    end else if (vld) begin
      case (op)
        2'b00: begin
          pu = longint'({32'h0, a}) * longint'({32'h0, b});
          m_hi = pu[63:32]; m_lo = pu[31:0];
        end
        2'b01: begin
          ps = longint'(int'(a)) * longint'(int'(b));
          m_hi = ps[63:32]; m_lo = ps[31:0];
        end
        2'b10: begin
          p   = int'(shortint'(a[15:0])) * int'(shortint'(b[15:0]));
          tot = {32'h0, m_lo} + {32'h0, 32'(p)};
          s   = tot[31:0];
          cy  = tot[32];
          if (sat) begin
            ovf = ((p < 0) == (int'(m_lo) < 0)) && ((int'(s) < 0) != (p < 0));
            if (ovf) begin
              m_hi = m_hi | 32'h1;
              m_lo = (p < 0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
            end else m_lo = s;
          end else begin
            t = int'(m_hi) + ((p < 0) ? -1 : 0) + int'(cy);
            m_hi = t[9] ? (32'(t) | ~32'h3FF) : (32'(t) & 32'h3FF);
            m_lo = s;
          end
        end
        default: ;
      endcase
    end
  endtask

  task automatic check(string req);
    checks++;
    if (mach_o !== m_hi || macl_o !== m_lo) begin
      errors++;
      $display("FAIL %s actual %h_%h expected %h_%h", req, mach_o, macl_o, m_hi, m_lo);
    end
  endtask

  // drive at negedge, clock, compare at the following negedge
  task automatic step(string req, bit clr, bit vld, bit [1:0] op, bit sat,
                      bit [31:0] a, bit [31:0] b);
    clr_i = clr; vld_i = vld; op_i = op; sat_i = sat; opa_i = a; opb_i = b;
    model_step(clr, vld, op, sat, a, b);
    @(posedge clk_i);
    @(negedge clk_i);
    check(req);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1");

    // full multiplies
    step("R3", 0, 1, 2'b00, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    step("R3", 0, 1, 2'b00, 0, 32'h1234_5678, 32'h9ABC_DEF0);
    step("R4", 0, 1, 2'b01, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    step("R4", 0, 1, 2'b01, 0, 32'h8000_0000, 32'h7FFF_FFFF);
    step("R4", 0, 1, 2'b01, 0, 32'h8000_0000, 32'h8000_0000);
    step("R4", 0, 1, 2'b01, 0, 32'hFFFF_FF9C, 32'h0001_0003);

    // clear beats a valid operation
    step("R2", 1, 1, 2'b00, 0, 32'hFFFF_FFFF, 32'h3);

    // wrapping accumulate; upper operand halves must not matter
    step("R5", 0, 1, 2'b10, 0, 32'hDEAD_0003, 32'hBEEF_0004);
    step("R5", 0, 1, 2'b10, 0, 32'h0000_FFFF, 32'h0000_0010);
    step("R6", 0, 1, 2'b10, 0, 32'h0000_8000, 32'h0000_7FFF);
    // guard field crossing: high word 0x1FF, low all ones, then carry in
    step("R6", 0, 1, 2'b00, 0, 32'd13367, 32'd164511353);
    step("R6", 0, 1, 2'b10, 0, 32'h1, 32'h1);
    step("R6", 0, 1, 2'b10, 0, 32'hFFFF, 32'h1);

    // no-op and idle hold
    step("R10", 0, 1, 2'b11, 1, 32'h1234_5678, 32'h9ABC_DEF0);
    step("R10", 0, 0, 2'b00, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);

    // saturation positive, sticky bit
    step("R2", 1, 0, 2'b11, 0, 32'h0, 32'h0);
    step("R7", 0, 1, 2'b00, 0, 32'h7FFF_0000, 32'h1);
    step("R7", 0, 1, 2'b10, 1, 32'h0000_0002, 32'h0000_0003);
    step("R8", 0, 1, 2'b10, 1, 32'h0000_7FFF, 32'h0000_7FFF);
    step("R8", 0, 1, 2'b10, 1, 32'h0000_FFFF, 32'h0000_0001);
    step("R8", 0, 1, 2'b10, 1, 32'h0000_0005, 32'h0000_0001);

    // saturation negative
    step("R9", 0, 1, 2'b00, 0, 32'h8000_0010, 32'h1);
    step("R9", 0, 1, 2'b10, 1, 32'h0000_8000, 32'h0000_7FFF);
    step("R9", 0, 1, 2'b01, 0, 32'hFFFF_FFFE, 32'h4000_0000);
    step("R9", 0, 1, 2'b10, 1, 32'hABCD_8000, 32'h1234_0001);

    // mixed random sequence
    for (int k = 0; k < 400; k++) begin
      bit [1:0] op = 2'($urandom_range(0, 3));
      step("R3 R4 R5 R6 R7 R8 R9 R10",
           ($urandom_range(0, 15) == 0), ($urandom_range(0, 3) != 0), op,
           1'($urandom_range(0, 1)), $urandom, $urandom);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule